// File: doc/BRIEF.md
# Grouped Multi-Source Interrupt Controller

This block merges the interrupt conditions of three peripherals into a single request line toward a CPU core. The three peripherals are a serial port with six conditions, a two-wire bus interface with three conditions, and a periodic time base with one overflow condition. Each peripheral owns a sticky source flag and a source enable bit. On top of these sits a group pending flag with its own group enable bit, and a global enable bit gates everything. Software reaches all of these bits through one masked write port and two read-back buses.

A rising edge on the OR of a peripheral's conditions sets that peripheral's source flag and the group pending flag. The request line is raised when all of the following hold:

- a source flag and its enable are both set;
- the group pending flag and the group enable are both set;
- the global enable is set;
- the core reports that its call stack is not full.

A small sequencer holds the request until the core returns a one-cycle acknowledge. The acknowledge clears the global enable and the group pending flag. The source flags are left untouched for software to clear.

The sequencer has three states:

- IDLE waits for the request condition and moves to REQ when it holds.
- REQ drives the request line and moves to SERV when an acknowledge arrives.
- SERV represents the single level of service. It moves back to IDLE once software sets the global enable again.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every source flag, the group pending flag, every enable bit and `irq_req` are 0.
- R2: A rising edge of the OR of the six `ser_cond` bits sets the serial source flag, read at `flag_rd` bit 0, at the next clock edge. A condition bit that rises while another is still high is not a new edge.
- R3: A rising edge of the OR of `bus_cond` sets `flag_rd` bit 1. A rising edge of `tb_ovf` sets `flag_rd` bit 2.
- R4: Any source rising edge also sets the group pending flag, read at `flag_rd` bit 3.
- R5: `irq_req` rises one cycle after all of these hold together: a source flag with its enable (`ctrl_rd` bits 0..2, same order as the flags), the group flag, the group enable (`ctrl_rd` bit 3), the global enable (`ctrl_rd` bit 4) and `stack_full` low. If any of them is missing, `irq_req` stays low.
- R6: Once raised, `irq_req` is held until `irq_ack`. An `irq_ack` while `irq_req` is low changes nothing.
- R7: An accepted acknowledge clears `irq_req`, the global enable and the group pending flag at the next edge, and leaves every source flag unchanged. The global-enable clear wins over a software write to that bit in the same cycle.
- R8: After service, a source flag that stays set does not set the group flag again. Only a new rising edge on some source does, and after the global enable is restored that edge raises a new request.
- R9: A write with `reg_sel`=0 clears each flag bit whose `reg_wdata` and `reg_wmask` bits are both 1. A hardware set in the same cycle as a clear of the same flag wins.
- R10: A write with `reg_sel`=1 loads each enable bit whose `reg_wmask` bit is 1 from `reg_wdata` and keeps the others. A write to the flag register leaves the enables unchanged.
- R11: While `stack_full` is high no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_cond | input | 6 | Serial port interrupt conditions (levels) |
| bus_cond | input | 3 | Two-wire bus interrupt conditions (levels) |
| tb_ovf | input | 1 | Time base overflow condition |
| stack_full | input | 1 | Core call stack is full |
| irq_ack | input | 1 | One-cycle acknowledge from the core |
| irq_req | output | 1 | Vector request, level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = flag register, 1 = enable register |
| reg_wdata | input | 5 | Write data |
| reg_wmask | input | 5 | Per-bit write mask |
| flag_rd | output | 5 | {0, group flag, time base, bus, serial} |
| ctrl_rd | output | 5 | {global en, group en, time base en, bus en, serial en} |

## Verification
Two functions can fall in the same cycle:

- A peripheral's rising condition and a software write-one-to-clear of the same flag.
- The core's acknowledge and a software write that sets the global enable.

The bench drives each pair on the same falling edge, so both reach the same rising edge. It then reads back the flag or enable register. It expects the source flag to stay set in the first case and the global enable to be 0 in the second.

// File: rtl/gic_pkg.sv
package gic_pkg;
    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned SRC_SER  = 0;
    localparam int unsigned SRC_BUS  = 1;
    localparam int unsigned SRC_TB   = 2;
    localparam int unsigned BIT_GRP  = NUM_SRC;
    localparam int unsigned BIT_GLB  = NUM_SRC + 1;
    localparam int unsigned REG_W    = NUM_SRC + 2;
    localparam logic        SEL_FLAG = 1'b0;
    localparam logic        SEL_CTRL = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SERV = 2'd2
    } seq_state_t;
endpackage

// File: rtl/gic_src_flag.sv
module gic_src_flag #(
    parameter int unsigned N_COND = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond,
    input  logic              sw_clr,
    output logic              flag,
    output logic              rise
);
    logic any_c;
    logic prev_q;

    assign any_c = |cond;
    assign rise  = any_c & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= any_c;
            // hardware set has priority over software clear
            if (rise)
                flag <= 1'b1;
            else if (sw_clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/gic_ctrl_regs.sv
module gic_ctrl_regs
    import gic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [REG_W-1:0]   wmask,
    input  logic               hw_glb_clr,
    output logic [NUM_SRC-1:0] src_en,
    output logic               grp_en,
    output logic               glb_en
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
            grp_en <= 1'b0;
            glb_en <= 1'b0;
        end else begin
            if (wr) begin
                for (int i = 0; i < NUM_SRC; i++)
                    if (wmask[i]) src_en[i] <= wdata[i];
                if (wmask[BIT_GRP]) grp_en <= wdata[BIT_GRP];
                if (wmask[BIT_GLB]) glb_en <= wdata[BIT_GLB];
            end
            // service clear overrides a same-cycle software write
            if (hw_glb_clr) glb_en <= 1'b0;
        end
    end
endmodule

// File: rtl/gic_grp_seq.sv
module gic_grp_seq
    import gic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               grp_en,
    input  logic               glb_en,
    input  logic               stack_full,
    input  logic               irq_ack,
    input  logic               any_rise,
    input  logic               grp_sw_clr,
    output logic               grp_flag,
    output logic               irq_req,
    output logic               svc
);
    seq_state_t state_q, state_d;
    logic       gate;

    assign gate = (|(src_flag & src_en)) & grp_flag & grp_en & glb_en & ~stack_full;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (gate)    state_d = ST_REQ;
            ST_REQ:  if (irq_ack) state_d = ST_SERV;
            ST_SERV: if (glb_en)  state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req = 1'b0;
        svc     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ: begin
                irq_req = 1'b1;
                svc     = irq_ack;
            end
            ST_SERV: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            grp_flag <= 1'b0;
        else if (any_rise)
            grp_flag <= 1'b1;
        else if (svc || grp_sw_clr)
            grp_flag <= 1'b0;
    end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import gic_pkg::*;
#(
    parameter int unsigned SER_CONDS = 6,
    parameter int unsigned BUS_CONDS = 3,
    parameter int unsigned TB_CONDS  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SER_CONDS-1:0] ser_cond,
    input  logic [BUS_CONDS-1:0] bus_cond,
    input  logic [TB_CONDS-1:0]  tb_ovf,
    input  logic                 stack_full,
    input  logic                 irq_ack,
    output logic                 irq_req,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic [REG_W-1:0]     reg_wmask,
    output logic [REG_W-1:0]     flag_rd,
    output logic [REG_W-1:0]     ctrl_rd
);
    logic [NUM_SRC-1:0] src_flag;
    logic [NUM_SRC-1:0] src_rise;
    logic [NUM_SRC-1:0] src_clr;
    logic [NUM_SRC-1:0] src_en;
    logic [BIT_GRP:0]   clr_bits;
    logic               flag_wr, ctrl_wr;
    logic               grp_sw_clr;
    logic               any_rise;
    logic               grp_en, glb_en, grp_flag, svc;

    assign flag_wr  = reg_wr && (reg_sel == SEL_FLAG);
    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign clr_bits = reg_wdata[BIT_GRP:0] & reg_wmask[BIT_GRP:0];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
        assign src_clr[g] = flag_wr & clr_bits[g];
    end
    assign grp_sw_clr = flag_wr & clr_bits[BIT_GRP];
    assign any_rise   = |src_rise;

    gic_src_flag #(.N_COND(SER_CONDS)) u_ser (
        .clk(clk), .rst_n(rst_n), .cond(ser_cond), .sw_clr(src_clr[SRC_SER]),
        .flag(src_flag[SRC_SER]), .rise(src_rise[SRC_SER])
    );
    gic_src_flag #(.N_COND(BUS_CONDS)) u_bus (
        .clk(clk), .rst_n(rst_n), .cond(bus_cond), .sw_clr(src_clr[SRC_BUS]),
        .flag(src_flag[SRC_BUS]), .rise(src_rise[SRC_BUS])
    );
    gic_src_flag #(.N_COND(TB_CONDS)) u_tb (
        .clk(clk), .rst_n(rst_n), .cond(tb_ovf), .sw_clr(src_clr[SRC_TB]),
        .flag(src_flag[SRC_TB]), .rise(src_rise[SRC_TB])
    );

    gic_ctrl_regs u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(reg_wdata), .wmask(reg_wmask),
        .hw_glb_clr(svc), .src_en(src_en), .grp_en(grp_en), .glb_en(glb_en)
    );

    gic_grp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .grp_en(grp_en), .glb_en(glb_en), .stack_full(stack_full),
        .irq_ack(irq_ack), .any_rise(any_rise), .grp_sw_clr(grp_sw_clr),
        .grp_flag(grp_flag), .irq_req(irq_req), .svc(svc)
    );

    assign flag_rd = {1'b0, grp_flag, src_flag};
    assign ctrl_rd = {glb_en, grp_en, src_en};
endmodule

// File: rtl/irq_group_chk.sv
module irq_group_chk
    import gic_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic               irq_ack,
    input logic               stack_full,
    input logic               glb_en,
    input logic               grp_flag,
    input logic               any_rise,
    input logic [NUM_SRC-1:0] src_flag,
    input logic [NUM_SRC-1:0] src_rise,
    input logic [NUM_SRC-1:0] src_clr
);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack |=> !glb_en && !irq_req);

    p_grp_svc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && !any_rise |=> !grp_flag);

    p_grp_only_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_flag && !any_rise |=> !grp_flag);

    p_req_needs_grp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && !grp_flag |=> !irq_req);

    p_stack_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && stack_full |=> !irq_req);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        p_src_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
            src_flag[i] && !src_clr[i] |=> src_flag[i]);
        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            src_rise[i] |=> src_flag[i]);
    end
endmodule

bind irq_group_ctrl irq_group_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .stack_full(stack_full), .glb_en(glb_en), .grp_flag(grp_flag),
    .any_rise(any_rise), .src_flag(src_flag), .src_rise(src_rise), .src_clr(src_clr)
);

// File: tb/sim_irq_group_ctrl.sv
`timescale 1ns/1ps
module sim_irq_group_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ser_cond;
    logic [2:0] bus_cond;
    logic [0:0] tb_ovf;
    logic       stack_full, irq_ack, irq_req, reg_wr, reg_sel;
    logic [4:0] reg_wdata, reg_wmask, flag_rd, ctrl_rd;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_group_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ser_cond(ser_cond), .bus_cond(bus_cond),
        .tb_ovf(tb_ovf), .stack_full(stack_full), .irq_ack(irq_ack), .irq_req(irq_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_wmask(reg_wmask), .flag_rd(flag_rd), .ctrl_rd(ctrl_rd)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ser_cond = '0; bus_cond = '0; tb_ovf = '0;
        stack_full = 1'b0; irq_ack = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
        reg_wdata = '0; reg_wmask = '0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic sel, input logic [4:0] d, input logic [4:0] m);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_wmask = m;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; reg_wmask = '0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        tick(1);
        // R1 reset state
        chk("R1 flags", flag_rd, 5'b0);
        chk("R1 enables", ctrl_rd, 5'b0);
        chk("R1 irq_req", {4'b0, irq_req}, 5'b0);

        // R5 / R11 / R2 / R4 sweep over gating conditions
        for (int m = 0; m < 64; m++) begin
            logic b_evt, b_en, b_grp_en, b_glb, b_full, b_clr, exp_req;
            b_evt = m[0]; b_en = m[1]; b_grp_en = m[2];
            b_glb = m[3]; b_full = m[4]; b_clr = m[5];
            exp_req = b_evt & b_en & b_grp_en & b_glb & ~b_full & ~b_clr;
            do_reset();
            stack_full = b_full;
            if (b_evt) begin
                @(negedge clk); ser_cond[m % 6] = 1'b1;
                @(negedge clk); ser_cond = '0;
            end
            if (b_clr) wr_reg(1'b0, 5'b01000, 5'b01000);
            wr_reg(1'b1, {b_glb, b_grp_en, 2'b00, b_en}, 5'b11111);
            chk("R2 serial flag", {4'b0, flag_rd[0]}, {4'b0, b_evt});
            chk("R4 group flag", {4'b0, flag_rd[3]}, {4'b0, b_evt & ~b_clr});
            tick(2);
            chk("R5/R11 gated irq_req", {4'b0, irq_req}, {4'b0, exp_req});
        end

        // R2: second condition rising while first held is not a new edge
        do_reset();
        @(negedge clk); ser_cond[1] = 1'b1;
        tick(1);
        wr_reg(1'b0, 5'b01001, 5'b11111);
        @(negedge clk); ser_cond[3] = 1'b1;
        tick(1);
        chk("R2 overlapping condition no edge", flag_rd, 5'b00000);
        @(negedge clk); ser_cond = '0;

        // R3 bus and time base flags
        do_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); bus_cond[k] = 1'b1;
            @(negedge clk); bus_cond = '0;
            chk("R3 bus flag", flag_rd, 5'b01010);
            wr_reg(1'b0, 5'b11111, 5'b01010);
            chk("R9 bus flag cleared", flag_rd, 5'b00000);
        end
        @(negedge clk); tb_ovf = 1'b1;
        @(negedge clk); tb_ovf = 1'b0;
        chk("R3 time base flag", flag_rd, 5'b01100);

        // R9 masked clear
        @(negedge clk); ser_cond[5] = 1'b1;
        @(negedge clk); ser_cond = '0;
        wr_reg(1'b0, 5'b11111, 5'b00001);
        chk("R9 masked clear", flag_rd, 5'b01100);

        // R9 set wins over same-cycle clear
        @(negedge clk);
        bus_cond[2] = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 5'b00010; reg_wmask = 5'b00010;
        @(negedge clk);
        bus_cond = '0; reg_wr = 1'b0; reg_wdata = '0; reg_wmask = '0;
        chk("R9 set wins", flag_rd, 5'b01110);

        // R10 enable register read/write with mask
        do_reset();
        wr_reg(1'b1, 5'b10101, 5'b11111);
        chk("R10 enable write", ctrl_rd, 5'b10101);
        wr_reg(1'b1, 5'b01010, 5'b00011);
        chk("R10 masked enable write", ctrl_rd, 5'b10110);
        wr_reg(1'b0, 5'b11111, 5'b11111);
        chk("R10 flag write leaves enables", ctrl_rd, 5'b10110);

        // R6 ack while idle ignored
        wr_reg(1'b1, 5'b11111, 5'b11111);
        pulse_ack();
        chk("R6 idle ack ignored", ctrl_rd, 5'b11111);
        chk("R6 idle ack no req", {4'b0, irq_req}, 5'b0);

        // R5/R6/R7 request, hold, service
        @(negedge clk); ser_cond[2] = 1'b1;
        tick(2);
        chk("R5 irq_req raised", {4'b0, irq_req}, 5'b1);
        tick(6);
        chk("R6 irq_req held", {4'b0, irq_req}, 5'b1);
        pulse_ack();
        chk("R7 req dropped", {4'b0, irq_req}, 5'b0);
        chk("R7 global enable cleared", ctrl_rd, 5'b01111);
        chk("R7 group clear source kept", flag_rd, 5'b00001);

        // R8 no retrigger from a held source
        wr_reg(1'b1, 5'b10000, 5'b10000);
        tick(3);
        chk("R8 no retrigger", {4'b0, irq_req}, 5'b0);
        chk("R8 group flag stays clear", flag_rd, 5'b00001);
        @(negedge clk); ser_cond[4] = 1'b1;
        tick(3);
        chk("R8 overlapping no retrigger", {4'b0, irq_req}, 5'b0);
        @(negedge clk); ser_cond = '0;
        @(negedge clk); ser_cond[1] = 1'b1;
        tick(2);
        chk("R8 new edge requests", {4'b0, irq_req}, 5'b1);

        // R7 ack wins over same-cycle global-enable write
        @(negedge clk);
        irq_ack = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 5'b10000; reg_wmask = 5'b10000;
        @(negedge clk);
        irq_ack = 1'b0; reg_wr = 1'b0; reg_wdata = '0; reg_wmask = '0;
        chk("R7 ack beats write", {4'b0, ctrl_rd[4]}, 5'b0);
        @(negedge clk); ser_cond = '0;

        // R11 stack full blocks, release lets request through
        do_reset();
        stack_full = 1'b1;
        wr_reg(1'b1, 5'b11100, 5'b11111);
        @(negedge clk); tb_ovf = 1'b1;
        @(negedge clk); tb_ovf = 1'b0;
        tick(3);
        chk("R11 stack full blocks", {4'b0, irq_req}, 5'b0);
        @(negedge clk); stack_full = 1'b0;
        tick(2);
        chk("R11 released request", {4'b0, irq_req}, 5'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule